// File: doc/BRIEF.md
# Task Boot Selection and Device Start Control

This block holds the emulator-side control state that microcode writes from the 16-bit processor bus. It has three parts. The first is a per-task boot-bank register that says, for each of the 16 tasks, whether the task begins in ROM bank 0 or in RAM bank 0. The second is a small RAM bank number register. The third is a start-function decoder that turns a bus word into one of four results: a soft-reset request, a one-cycle start pulse to one of three device ports, or an error pulse for a code that no device owns.

Each part has its own load strobe, and all three take the bus word that is present in the cycle the strobe is high. Device start pulses and the soft-reset pulse appear one cycle after the strobe and last one cycle. The decoded code is driven on a shared data output while a device pulse is high. In the same cycle as a soft-reset request, a separate combinational output tells the sequencer not to take its next address from the next-address field.

Top module: `task_boot_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `boot_rom` is all ones, `ram_bank` is 0, and `soft_rst`, `net_go`, `prn_go`, `dsk_go`, `bad_go` are low with `go_code` equal to 0.
- R2: When `ld_boot` is high at a clock edge, `boot_rom` takes the bus word after that edge, with bus bit i giving the bit for task i (task 0 is the lowest priority and task 15 the highest). A bit value of 1 selects a ROM bank 0 start and 0 selects a RAM bank 0 start.
- R3: When `ld_boot` is low, `boot_rom` keeps its value, even if a start strobe or a bank load happens in that cycle.
- R4: A start strobe with a bus value of 0 produces no pulse of any kind, and `go_code` stays 0.
- R5: A start strobe with bus bit 15 set raises `soft_rst` for exactly the next cycle and raises no device or error pulse, whatever the lower bits are. In the strobe cycle itself, `hold_next` is high. `hold_next` is low in every other cycle.
- R6: When `ld_bank` is high, `ram_bank` takes bus bits 3:1 if `big_ram` is high, and takes 0 if `big_ram` is low.
- R7: With bit 15 clear, start codes 1, 2 and 3 pulse `net_go`, code 4 pulses `prn_go`, and codes 0x10 and 0x20 pulse `dsk_go`.
- R8: Every pulse lasts one cycle. A device pulse carries the start code on `go_code`, and `go_code` is 0 in every cycle without a device pulse.
- R9: A nonzero start code with bit 15 clear that matches none of the codes in R7 pulses `bad_go` for one cycle and no device output.
- R10: A boot-register load, a bank load and a start strobe in the same cycle all act on the same bus word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus | input | 16 | Processor bus word |
| ld_boot | input | 1 | Load strobe for the boot-bank register |
| ld_bank | input | 1 | Load strobe for the RAM bank register |
| start | input | 1 | Start-function strobe |
| big_ram | input | 1 | Configuration: large RAM present |
| boot_rom | output | 16 | Per-task start selection, 1 = ROM bank 0 |
| ram_bank | output | 3 | Current RAM bank number |
| hold_next | output | 1 | Same-cycle request to skip the next-address load |
| soft_rst | output | 1 | Soft-reset pulse |
| net_go | output | 1 | Network port start pulse |
| prn_go | output | 1 | Printer-interface port start pulse |
| dsk_go | output | 1 | Disk port start pulse |
| bad_go | output | 1 | Unknown start code pulse |
| go_code | output | 16 | Start code during a device pulse |

## Verification
The boot-register load and the start function both read the bus, and they can be strobed in the same cycle. The bench provokes this by raising `ld_boot` together with `start`, using a soft-reset word, a network code, an unknown code and a zero word. The scoreboard then expects both the new register image and the decoded pulse one cycle later. A bank load is also driven in the same cycle, so that one bus word reaches all three consumers. Each effect is compared independently, so if one function suppressed or corrupted the other, that field would be reported.

// File: rtl/boot_ctrl_pkg.sv
package boot_ctrl_pkg;
  localparam int BUS_W  = 16;
  localparam int TASKS  = 16;
  localparam int BANK_W = 3;
  localparam int BANK_LSB = 1;
  localparam int SOFT_BIT = BUS_W - 1;

  typedef enum logic [2:0] {
    DST_NONE, DST_NET, DST_PRN, DST_DSK, DST_BAD, DST_SOFT
  } dest_e;

  // Routing of a start word to its destination; soft reset wins over all codes.
  function automatic dest_e classify(input logic [BUS_W-1:0] v);
    dest_e d;
    if (v[SOFT_BIT])          d = DST_SOFT;
    else if (v == '0)         d = DST_NONE;
    else begin
      case (v)
        16'h0001, 16'h0002, 16'h0003: d = DST_NET;
        16'h0004:                     d = DST_PRN;
        16'h0010, 16'h0020:           d = DST_DSK;
        default:                      d = DST_BAD;
      endcase
    end
    return d;
  endfunction

  // Bank value taken from the bus, zeroed on a small-RAM machine.
  function automatic logic [BANK_W-1:0] bank_of(input logic [BANK_W-1:0] f,
                                               input logic big);
    return big ? f : '0;
  endfunction
endpackage

// File: rtl/boot_mode_reg.sv
module boot_mode_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // One flop per task, each presets to ROM start.
  for (genvar i = 0; i < N; i++) begin : g_task
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b1;
      else if (ld) q[i] <= d[i];
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));
endmodule

// File: rtl/ram_bank_reg.sv
module ram_bank_reg
  import boot_ctrl_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         big,
  input  logic [W-1:0] f,
  output logic [W-1:0] bank
);
  logic [W-1:0] nxt;
  assign nxt = big ? f : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bank <= '0;
    else if (ld) bank <= nxt;
  end

  p_small_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !big) |=> (bank == '0));
  p_big_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && big) |=> (bank == $past(f)));
endmodule

// File: rtl/start_decoder.sv
module start_decoder
  import boot_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] word,
  output logic             hold_next,
  output logic             soft_rst,
  output logic             net_go,
  output logic             prn_go,
  output logic             dsk_go,
  output logic             bad_go,
  output logic [BUS_W-1:0] go_code
);
  dest_e dst;
  logic  dev_hit;

  assign dst       = start ? classify(word) : DST_NONE;
  assign dev_hit   = (dst == DST_NET) || (dst == DST_PRN) || (dst == DST_DSK);
  assign hold_next = (dst == DST_SOFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst <= 1'b0;
      net_go   <= 1'b0;
      prn_go   <= 1'b0;
      dsk_go   <= 1'b0;
      bad_go   <= 1'b0;
      go_code  <= '0;
    end else begin
      soft_rst <= (dst == DST_SOFT);
      net_go   <= (dst == DST_NET);
      prn_go   <= (dst == DST_PRN);
      dsk_go   <= (dst == DST_DSK);
      bad_go   <= (dst == DST_BAD);
      go_code  <= dev_hit ? word : '0;
    end
  end

  // Internal event wire for the checks below.
  logic any_pulse;
  assign any_pulse = soft_rst | net_go | prn_go | dsk_go | bad_go;

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_rst, net_go, prn_go, dsk_go, bad_go}));
  p_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && word[SOFT_BIT]) |=> (soft_rst && !net_go && !prn_go && !dsk_go && !bad_go));
  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && word == '0) |=> (!any_pulse && go_code == '0));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!any_pulse && go_code == '0));
  p_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (net_go || prn_go || dsk_go) |-> (go_code != '0 && !go_code[SOFT_BIT]));
endmodule

// File: rtl/task_boot_ctrl.sv
module task_boot_ctrl
  import boot_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus,
  input  logic        ld_boot,
  input  logic        ld_bank,
  input  logic        start,
  input  logic        big_ram,
  output logic [15:0] boot_rom,
  output logic [2:0]  ram_bank,
  output logic        hold_next,
  output logic        soft_rst,
  output logic        net_go,
  output logic        prn_go,
  output logic        dsk_go,
  output logic        bad_go,
  output logic [15:0] go_code
);
  boot_mode_reg #(.N(TASKS)) u_mode (
    .clk(clk), .rst_n(rst_n), .ld(ld_boot), .d(bus[TASKS-1:0]), .q(boot_rom)
  );

  ram_bank_reg #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld(ld_bank), .big(big_ram),
    .f(bus[BANK_LSB+BANK_W-1:BANK_LSB]), .bank(ram_bank)
  );

  start_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .start(start), .word(bus),
    .hold_next(hold_next), .soft_rst(soft_rst), .net_go(net_go),
    .prn_go(prn_go), .dsk_go(dsk_go), .bad_go(bad_go), .go_code(go_code)
  );

  p_hold_only_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_next |=> soft_rst);
endmodule

// File: tb/task_boot_ctrl_test.sv
`timescale 1ns/1ps
module task_boot_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus = '0;
  logic        ld_boot = 1'b0, ld_bank = 1'b0, start = 1'b0, big_ram = 1'b0;
  logic [15:0] boot_rom, go_code;
  logic [2:0]  ram_bank;
  logic        hold_next, soft_rst, net_go, prn_go, dsk_go, bad_go;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  task_boot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus(bus), .ld_boot(ld_boot), .ld_bank(ld_bank),
    .start(start), .big_ram(big_ram), .boot_rom(boot_rom), .ram_bank(ram_bank),
    .hold_next(hold_next), .soft_rst(soft_rst), .net_go(net_go), .prn_go(prn_go),
    .dsk_go(dsk_go), .bad_go(bad_go), .go_code(go_code)
  );

  typedef struct {
    logic [15:0] mode;
    logic [2:0]  bank;
    logic [4:0]  pulses;   // {soft, net, prn, dsk, bad}
    logic [15:0] code;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [15:0] m_mode = 16'hFFFF;
  logic [2:0]  m_bank = 3'd0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit lm, input bit lb, input bit st, input bit big,
                       input logic [15:0] w, input string tag);
    exp_t e;
    logic [4:0] p;
    logic [15:0] c;
    @(negedge clk);
    ld_boot = lm; ld_bank = lb; start = st; big_ram = big; bus = w;
    if (lm) m_mode = w;
    if (lb) m_bank = big ? {w[3], w[2], w[1]} : 3'd0;
    p = 5'b0; c = 16'h0;
    if (st) begin
      if (w >= 16'h8000)                      p = 5'b10000;
      else if (w == 0)                        p = 5'b00000;
      else if (w <= 3)                        begin p = 5'b01000; c = w; end
      else if (w == 4)                        begin p = 5'b00100; c = w; end
      else if (w == 16'h10 || w == 16'h20)    begin p = 5'b00010; c = w; end
      else                                    p = 5'b00001;
    end
    e.mode = m_mode; e.bank = m_bank; e.pulses = p; e.code = c; e.tag = tag;
    q.push_back(e);
    #1;
    check(hold_next == (st && w[15]), "R5", "hold_next", 32'(hold_next), 32'(st && w[15]));
  endtask

  // Monitor: compares each queued item just after the edge that produces it.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(boot_rom == e.mode, e.tag, "boot_rom", 32'(boot_rom), 32'(e.mode));
        check(ram_bank == e.bank, e.tag, "ram_bank", 32'(ram_bank), 32'(e.bank));
        check({soft_rst, net_go, prn_go, dsk_go, bad_go} == e.pulses, e.tag, "pulses",
              32'({soft_rst, net_go, prn_go, dsk_go, bad_go}), 32'(e.pulses));
        check(go_code == e.code, e.tag, "go_code", 32'(go_code), 32'(e.code));
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 5000) begin @(posedge clk); wd++; end
    if (!done) begin
      check(1'b0, "WATCHDOG", "timeout", 32'(wd), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(boot_rom == 16'hFFFF, "R1", "boot_rom", 32'(boot_rom), 32'hFFFF);
    check(ram_bank == 3'd0, "R1", "ram_bank", 32'(ram_bank), 32'd0);
    check({soft_rst, net_go, prn_go, dsk_go, bad_go, hold_next} == 6'b0, "R1", "pulses",
          32'({soft_rst, net_go, prn_go, dsk_go, bad_go}), 32'd0);
    check(go_code == 16'h0, "R1", "go_code", 32'(go_code), 32'd0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 16'h0000, "R1");
    // R2 loads, R3 holds
    drive(1, 0, 0, 0, 16'hA5C3, "R2");
    drive(0, 0, 0, 0, 16'h1234, "R3");
    drive(1, 0, 0, 0, 16'h0001, "R2");
    drive(0, 1, 1, 1, 16'h0003, "R3");
    // R6 bank
    drive(0, 1, 0, 1, 16'h000E, "R6");
    drive(0, 1, 0, 1, 16'hFFF5, "R6");
    drive(0, 1, 0, 0, 16'h000E, "R6");
    drive(0, 1, 0, 1, 16'h0004, "R6");
    // R4 zero, R5 soft reset
    drive(0, 0, 1, 0, 16'h0000, "R4");
    drive(0, 0, 1, 0, 16'h8000, "R5");
    drive(0, 0, 1, 0, 16'h8004, "R5");
    drive(0, 0, 1, 0, 16'hFFFF, "R5");
    // R7 routing, back-to-back pulses and idle gaps for R8
    for (int i = 1; i <= 4; i++) drive(0, 0, 1, 0, 16'(i), "R7");
    drive(0, 0, 0, 0, 16'h0010, "R8");
    drive(0, 0, 1, 0, 16'h0010, "R7");
    drive(0, 0, 1, 0, 16'h0020, "R7");
    drive(0, 0, 0, 0, 16'h0020, "R8");
    // R9 unknown codes
    drive(0, 0, 1, 0, 16'h0005, "R9");
    drive(0, 0, 1, 0, 16'h0030, "R9");
    drive(0, 0, 1, 0, 16'h7FFF, "R9");
    drive(0, 0, 1, 0, 16'h0011, "R9");
    // R10 simultaneous loads and start
    drive(1, 1, 1, 1, 16'h8006, "R10");
    drive(1, 1, 1, 1, 16'h0002, "R10");
    drive(1, 0, 1, 0, 16'h0040, "R10");
    drive(1, 1, 1, 0, 16'h0000, "R10");
    drive(0, 0, 0, 0, 16'h0000, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule